// File: doc/BRIEF.md
# Configuration Access Request Encoder

This block sits in front of a PCI host bridge and turns one configuration request into the words the bridge drives. A request names a bus, a device slot, a function, a register offset, an access size of 1, 2 or 4 bytes, a direction, and whether it targets the bridge's own register file (local) or a device on the bus (remote). The block answers with a 32-bit address word, a 32-bit command word that carries the active-low byte enables, and the write data moved onto its byte lanes. A size and offset pair that no lane pattern fits is refused and flagged.

Requests enter through a valid/ready handshake and leave as registered words with their own valid/ready pair. When the bridge returns read data, the block moves it back down to bit 0 and masks it to the access size, using the offset and size of the last command it issued. If the bridge reports a bus error, the result becomes all ones within the size mask and a not-found flag is raised.

Top module: `cfg_req_encoder`

## Requirements
- R1: For a remote request with bus number 0, out_addr = (1 << slot) | (function << 8) | (offset with bits 1:0 cleared).
- R2: For a remote request with a non-zero bus number, out_addr = (bus << 16) | (slot << 11) | (function << 8) | (offset with bits 1:0 cleared) | 1.
- R3: The active-low byte-enable nibble is 0xE, 0xD, 0xB, 0x7 for 1-byte accesses at offset[1:0] = 0, 1, 2, 3; 0xC and 0x3 for 2-byte accesses at offset[1:0] = 0 and 2; 0x0 for a 4-byte access at offset[1:0] = 0.
- R4: The byte-enable nibble sits in out_cmd[7:4] for remote requests and in out_cmd[23:20] for local requests; all other out_cmd bits not named in R5 are 0.
- R5: A remote command carries 0xA (read) or 0xB (write) in out_cmd[3:0]. A local command sets out_cmd[16] for a write, clears it for a read, and carries the offset with bits 1:0 cleared in out_cmd[7:0]; for a local request out_addr equals that aligned offset and the bus, slot and function inputs have no effect.
- R6: out_wdata equals req_wdata shifted left by 8 × offset[1:0].
- R7: A read response without error gives rd_data = (rsp_data >> 8 × offset[1:0]) masked to 0xFF, 0xFFFF or 0xFFFFFFFF for sizes 1, 2, 4 of the last issued command, with rd_not_found = 0, one cycle after rsp_valid.
- R8: A read response with rsp_err = 1 gives rd_data equal to the size mask (all ones within it), ignoring rsp_data, and rd_not_found = 1.
- R9: A request whose size (req_size encoding 1, 2 or 4) and offset match no entry of R3 raises out_invalid for the single cycle after acceptance and produces no out_valid.
- R10: While out_valid = 1 and out_ready = 0, req_ready is 0 and out_addr, out_cmd, out_wdata and out_valid hold their values.
- R11: After reset, out_valid, out_invalid and rd_valid are 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bus | input | BUS_W | Bus number |
| req_slot | input | SLOT_W | Device slot |
| req_func | input | FUNC_W | Function number |
| req_off | input | OFF_W | Register byte offset |
| req_size | input | 3 | Access size in bytes (1, 2, 4) |
| req_write | input | 1 | 1 write, 0 read |
| req_local | input | 1 | 1 targets the bridge's own registers |
| req_wdata | input | DATA_W | Write data, right aligned |
| out_valid | output | 1 | Encoded command present |
| out_ready | input | 1 | Bridge takes the command |
| out_addr | output | DATA_W | Address word |
| out_cmd | output | DATA_W | Command and byte-enable word |
| out_wdata | output | DATA_W | Lane-aligned write data |
| out_invalid | output | 1 | One-cycle pulse for a refused request |
| rsp_valid | input | 1 | Read data returned by the bridge |
| rsp_data | input | DATA_W | Raw returned dword |
| rsp_err | input | 1 | Bus error on the access |
| rd_valid | output | 1 | Extracted read result present |
| rd_data | output | DATA_W | Shifted and masked read result |
| rd_not_found | output | 1 | Access ended in a bus error |

## Verification
The hardest situation to reach is a stalled command with a different request already waiting at the input: the words must not move, and the waiting request must go through in the very cycle the stall lifts. The bench holds out_ready low after one accepted command, drives a second, distinct request for several cycles, checks the held words, then releases the stall and checks that the second request's words appear next. Error responses are sent after sub-dword requests so that the all-ones forcing is seen through the shift and size mask.

// File: rtl/cfg_enc_pkg.sv
package cfg_enc_pkg;

   typedef enum logic [3:0] {
      CMD_CFG_RD = 4'hA,
      CMD_CFG_WR = 4'hB
   } cfg_cmd_e;

   localparam int unsigned LCL_WR_BIT  = 16;
   localparam int unsigned LCL_BE_LSB  = 20;
   localparam int unsigned RMT_BE_LSB  = 4;
   localparam int unsigned T1_BUS_LSB  = 16;
   localparam int unsigned T1_SLOT_LSB = 11;
   localparam int unsigned FUNC_LSB    = 8;

   function automatic logic [31:0] size_mask(input logic [2:0] size);
      case (size)
         3'd1:    size_mask = 32'h0000_00FF;
         3'd2:    size_mask = 32'h0000_FFFF;
         3'd4:    size_mask = 32'hFFFF_FFFF;
         default: size_mask = 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/cfg_lane_gen.sv
module cfg_lane_gen (
   input  logic [2:0] size,
   input  logic [1:0] off_lo,
   output logic [3:0] be_n,
   output logic       legal
);
   always_comb begin
      be_n  = 4'hF;
      legal = 1'b0;
      case (size)
         3'd1: begin
            be_n  = ~(4'b0001 << off_lo);
            legal = 1'b1;
         end
         3'd2: begin
            if (off_lo == 2'd0) begin
               be_n  = 4'hC;
               legal = 1'b1;
            end else if (off_lo == 2'd2) begin
               be_n  = 4'h3;
               legal = 1'b1;
            end
         end
         3'd4: begin
            if (off_lo == 2'd0) begin
               be_n  = 4'h0;
               legal = 1'b1;
            end
         end
         default: begin
            be_n  = 4'hF;
            legal = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned SLOT_W = 5,
   parameter int unsigned FUNC_W = 3,
   parameter int unsigned OFF_W  = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic [BUS_W-1:0]  bus,
   input  logic [SLOT_W-1:0] slot,
   input  logic [FUNC_W-1:0] func,
   input  logic [OFF_W-1:0]  off,
   input  logic              lcl,
   output logic [DATA_W-1:0] addr
);
   import cfg_enc_pkg::*;

   logic [DATA_W-1:0] dw_off;
   logic [DATA_W-1:0] fn_part;
   logic [DATA_W-1:0] type0_w;
   logic [DATA_W-1:0] type1_w;

   assign dw_off  = DATA_W'({off[OFF_W-1:2], 2'b00});
   assign fn_part = DATA_W'(func) << FUNC_LSB;
   assign type0_w = (DATA_W'(1) << slot) | fn_part | dw_off;
   assign type1_w = (DATA_W'(bus) << T1_BUS_LSB) | (DATA_W'(slot) << T1_SLOT_LSB)
                  | fn_part | dw_off | DATA_W'(1);

   always_comb begin
      if (lcl)
         addr = dw_off;
      else if (bus == '0)
         addr = type0_w;
      else
         addr = type1_w;
   end
endmodule

// File: rtl/cfg_read_align.sv
module cfg_read_align #(
   parameter int unsigned DATA_W  = 32,
   parameter bit          REG_RSP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic              rsp_err,
   input  logic [1:0]        off_lo,
   input  logic [2:0]        size,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_not_found
);
   import cfg_enc_pkg::*;

   logic [DATA_W-1:0] src;
   logic [DATA_W-1:0] result;

   assign src    = rsp_err ? '1 : rsp_data;
   assign result = (src >> {off_lo, 3'b000}) & size_mask(size);

   generate
      if (REG_RSP) begin : gen_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_valid     <= 1'b0;
               rd_data      <= '0;
               rd_not_found <= 1'b0;
            end else begin
               rd_valid <= rsp_valid;
               if (rsp_valid) begin
                  rd_data      <= result;
                  rd_not_found <= rsp_err;
               end
            end
         end
      end else begin : gen_comb
         assign rd_valid     = rsp_valid;
         assign rd_data      = result;
         assign rd_not_found = rsp_valid & rsp_err;
      end
   endgenerate
endmodule

// File: rtl/cfg_req_encoder.sv
module cfg_req_encoder #(
   parameter int unsigned BUS_W   = 8,
   parameter int unsigned SLOT_W  = 5,
   parameter int unsigned FUNC_W  = 3,
   parameter int unsigned OFF_W   = 8,
   parameter int unsigned DATA_W  = 32,
   parameter bit          REG_RSP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [SLOT_W-1:0] req_slot,
   input  logic [FUNC_W-1:0] req_func,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [2:0]        req_size,
   input  logic              req_write,
   input  logic              req_local,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_cmd,
   output logic [DATA_W-1:0] out_wdata,
   output logic              out_invalid,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic              rsp_err,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_not_found
);
   import cfg_enc_pkg::*;

   initial begin
      assert (DATA_W == 32) else $error("DATA_W must be 32");
      assert (BUS_W >= 1 && BUS_W <= 8) else $error("BUS_W out of range");
      assert (SLOT_W == 5) else $error("SLOT_W must be 5");
      assert (FUNC_W == 3) else $error("FUNC_W must be 3");
      assert (OFF_W >= 2 && OFF_W <= 8) else $error("OFF_W out of range");
   end

   logic [3:0]        be_n;
   logic              legal;
   logic [DATA_W-1:0] addr_c;
   logic [DATA_W-1:0] cmd_c;
   logic [DATA_W-1:0] wdata_c;
   logic              accept;
   logic [1:0]        held_off_lo;
   logic [2:0]        held_size;
   logic              held_local;

   cfg_lane_gen u_lane (
      .size   (req_size),
      .off_lo (req_off[1:0]),
      .be_n   (be_n),
      .legal  (legal)
   );

   cfg_addr_gen #(
      .BUS_W(BUS_W), .SLOT_W(SLOT_W), .FUNC_W(FUNC_W),
      .OFF_W(OFF_W), .DATA_W(DATA_W)
   ) u_addr (
      .bus  (req_bus),
      .slot (req_slot),
      .func (req_func),
      .off  (req_off),
      .lcl  (req_local),
      .addr (addr_c)
   );

   always_comb begin
      if (req_local)
         cmd_c = (DATA_W'(be_n) << LCL_BE_LSB) | (DATA_W'(req_write) << LCL_WR_BIT)
               | DATA_W'({req_off[OFF_W-1:2], 2'b00});
      else
         cmd_c = (DATA_W'(be_n) << RMT_BE_LSB)
               | DATA_W'(req_write ? CMD_CFG_WR : CMD_CFG_RD);
   end

   assign wdata_c   = req_wdata << {req_off[1:0], 3'b000};
   assign req_ready = !out_valid || out_ready;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_invalid <= 1'b0;
         out_addr    <= '0;
         out_cmd     <= '0;
         out_wdata   <= '0;
         held_off_lo <= 2'd0;
         held_size   <= 3'd4;
         held_local  <= 1'b0;
      end else begin
         out_invalid <= accept && !legal;
         if (accept) begin
            out_valid <= legal;
            if (legal) begin
               out_addr    <= addr_c;
               out_cmd     <= cmd_c;
               out_wdata   <= wdata_c;
               held_off_lo <= req_off[1:0];
               held_size   <= req_size;
               held_local  <= req_local;
            end
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   cfg_read_align #(.DATA_W(DATA_W), .REG_RSP(REG_RSP)) u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .rsp_valid    (rsp_valid),
      .rsp_data     (rsp_data),
      .rsp_err      (rsp_err),
      .off_lo       (held_off_lo),
      .size         (held_size),
      .rd_valid     (rd_valid),
      .rd_data      (rd_data),
      .rd_not_found (rd_not_found)
   );
endmodule

// File: rtl/cfg_req_encoder_chk.sv
module cfg_req_encoder_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_addr,
   input logic [DATA_W-1:0] out_cmd,
   input logic [DATA_W-1:0] out_wdata,
   input logic              out_invalid,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_not_found,
   input logic              held_local
);
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_addr)
                                  && $stable(out_cmd) && $stable(out_wdata));

   assert_noissue_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_invalid |-> !out_valid);

   assert_accepted_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_invalid |-> $past(req_valid && req_ready));

   assert_be_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !held_local |-> out_cmd[7:4] inside
         {4'hE, 4'hD, 4'hB, 4'h7, 4'hC, 4'h3, 4'h0});

   assert_rmt_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !held_local |-> out_cmd[3:0] inside {4'hA, 4'hB});

   assert_notfound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && rd_not_found |-> rd_data[7:0] == 8'hFF);
endmodule

bind cfg_req_encoder cfg_req_encoder_chk #(.DATA_W(DATA_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_addr     (out_addr),
   .out_cmd      (out_cmd),
   .out_wdata    (out_wdata),
   .out_invalid  (out_invalid),
   .rd_valid     (rd_valid),
   .rd_data      (rd_data),
   .rd_not_found (rd_not_found),
   .held_local   (held_local)
);

// File: tb/cfg_req_encoder_tb.sv
module cfg_req_encoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_slot = '0;
   logic [2:0]  req_func = '0;
   logic [7:0]  req_off = '0;
   logic [2:0]  req_size = 3'd4;
   logic        req_write = 1'b0;
   logic        req_local = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_addr;
   logic [31:0] out_cmd;
   logic [31:0] out_wdata;
   logic        out_invalid;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_data = '0;
   logic        rsp_err = 1'b0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        rd_not_found;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   cfg_req_encoder dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_bus(req_bus), .req_slot(req_slot), .req_func(req_func),
      .req_off(req_off), .req_size(req_size), .req_write(req_write),
      .req_local(req_local), .req_wdata(req_wdata),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_addr(out_addr), .out_cmd(out_cmd), .out_wdata(out_wdata),
      .out_invalid(out_invalid),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_not_found(rd_not_found)
   );

   typedef struct packed {
      logic [7:0]  bus;
      logic [4:0]  slot;
      logic [2:0]  func;
      logic [7:0]  off;
      logic [2:0]  size;
      logic        wr;
      logic        lcl;
      logic [31:0] wd;
      logic [31:0] ea;
      logic [31:0] ec;
      logic [31:0] ew;
      logic        inv;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      // R1 type 0, 4-byte remote read
      '{8'd0,   5'd3,  3'd0, 8'h04, 3'd4, 1'b0, 1'b0, 32'h0, 32'h0000000C, 32'h0000000A, 32'h0, 1'b0},
      // R1 R3 R6 type 0, 1-byte remote write at offset 1
      '{8'd0,   5'd20, 3'd2, 8'h11, 3'd1, 1'b1, 1'b0, 32'h5A, 32'h00100210, 32'h000000DB, 32'h00005A00, 1'b0},
      // R2 R3 R6 type 1, 2-byte read at offset 2
      '{8'd5,   5'd7,  3'd1, 8'h3E, 3'd2, 1'b0, 1'b0, 32'h1234, 32'h0005393D, 32'h0000003A, 32'h12340000, 1'b0},
      // R2 type 1 with every field at its maximum
      '{8'hFF,  5'd31, 3'd7, 8'hFC, 3'd4, 1'b1, 1'b0, 32'hDEADBEEF, 32'h00FFFFFD, 32'h0000000B, 32'hDEADBEEF, 1'b0},
      // R4 R5 local 4-byte write, bus/slot/func ignored
      '{8'd3,   5'd9,  3'd5, 8'h04, 3'd4, 1'b1, 1'b1, 32'h356, 32'h00000004, 32'h00010004, 32'h356, 1'b0},
      // R4 R5 R6 local 1-byte read at offset 3
      '{8'd0,   5'd1,  3'd0, 8'h0B, 3'd1, 1'b0, 1'b1, 32'hAB, 32'h00000008, 32'h00700008, 32'hAB000000, 1'b0},
      // R9 2-byte access at offset 1
      '{8'd0,   5'd2,  3'd0, 8'h01, 3'd2, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1},
      // R9 size code 3
      '{8'd0,   5'd2,  3'd0, 8'h00, 3'd3, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1},
      // R4 R5 local 2-byte write at offset 2
      '{8'd3,   5'd9,  3'd0, 8'h42, 3'd2, 1'b1, 1'b1, 32'hBEEF, 32'h00000040, 32'h00310040, 32'hBEEF0000, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      req_bus   = v.bus;  req_slot = v.slot; req_func = v.func;
      req_off   = v.off;  req_size = v.size; req_write = v.wr;
      req_local = v.lcl;  req_wdata = v.wd;
   endtask

   task automatic issue(input vec_t v);
      @(negedge clk);
      drive(v);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic rd_case(input string tag, input logic [7:0] off, input logic [2:0] size,
                          input logic [31:0] data, input logic err,
                          input logic [31:0] exp, input logic exp_nf);
      vec_t v;
      v = '{8'd0, 5'd1, 3'd0, off, size, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0};
      issue(v);
      rsp_valid = 1'b1; rsp_data = data; rsp_err = err;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_err = 1'b0;
      check({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
      check({tag, " rd_data"}, rd_data, exp);
      check({tag, " rd_not_found"}, 32'(rd_not_found), 32'(exp_nf));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 out_valid", 32'(out_valid), 32'd0);
      check("R11 out_invalid", 32'(out_invalid), 32'd0);
      check("R11 rd_valid", 32'(rd_valid), 32'd0);
      check("R11 req_ready", 32'(req_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         issue(VECS[i]);
         check($sformatf("R9 vec%0d out_invalid", i), 32'(out_invalid), 32'(VECS[i].inv));
         check($sformatf("R9 vec%0d out_valid", i), 32'(out_valid), 32'(!VECS[i].inv));
         if (!VECS[i].inv) begin
            check($sformatf("R1/R2/R5 vec%0d out_addr", i), out_addr, VECS[i].ea);
            check($sformatf("R3/R4/R5 vec%0d out_cmd", i), out_cmd, VECS[i].ec);
            check($sformatf("R6 vec%0d out_wdata", i), out_wdata, VECS[i].ew);
         end
      end

      // R9 the invalid flag lasts one cycle only
      issue(VECS[6]);
      @(negedge clk);
      check("R9 pulse ended", 32'(out_invalid), 32'd0);
      check("R9 still no command", 32'(out_valid), 32'd0);

      // R10 stall with a different request waiting
      out_ready = 1'b0;
      issue(VECS[0]);
      drive(VECS[3]);
      req_valid = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 req_ready low", 32'(req_ready), 32'd0);
      check("R10 out_valid held", 32'(out_valid), 32'd1);
      check("R10 out_addr held", out_addr, VECS[0].ea);
      check("R10 out_cmd held", out_cmd, VECS[0].ec);
      out_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 next out_addr", out_addr, VECS[3].ea);
      check("R10 next out_cmd", out_cmd, VECS[3].ec);
      @(negedge clk);
      check("R10 drained", 32'(out_valid), 32'd0);

      // R7 read extraction
      rd_case("R7 b1 off1", 8'h05, 3'd1, 32'h11223344, 1'b0, 32'h00000033, 1'b0);
      rd_case("R7 b2 off2", 8'h06, 3'd2, 32'h11223344, 1'b0, 32'h00001122, 1'b0);
      rd_case("R7 b4 off0", 8'h08, 3'd4, 32'h11223344, 1'b0, 32'h11223344, 1'b0);
      rd_case("R7 b1 off3", 8'h0F, 3'd1, 32'hA1B2C3D4, 1'b0, 32'h000000A1, 1'b0);
      // R8 error forcing
      rd_case("R8 b1 off1", 8'h05, 3'd1, 32'h00000000, 1'b1, 32'h000000FF, 1'b1);
      rd_case("R8 b4 off0", 8'h00, 3'd4, 32'h12345678, 1'b1, 32'hFFFFFFFF, 1'b1);
      rd_case("R8 b2 off2", 8'h02, 3'd2, 32'h0, 1'b1, 32'h0000FFFF, 1'b1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule